// File: doc/BRIEF.md
# VLIW Group Sub-Program Counter

This block keeps a second, group-relative program counter while a VLIW group runs. When a group starts, the block captures the group's base address and byte length. The architectural PC output then holds the base for the whole group. A sub-PC starts at zero and advances by the byte size of each embedded instruction that completes. When the sub-PC reaches the group length, the group-active flag drops. From then on the remap and predicate entries no longer apply, and the core returns to normal mode.

Branches inside a group carry a signed offset from the current sub-PC. The target must lie inside the group. A target outside the group is refused: the illegal-branch flag is raised and the sub-PC is left unchanged. On a trap, the sub-PC is stored into one of four exception sub-PC registers, chosen by privilege level. On a return, the stored value is reloaded from that register. The four registers can also be read and written as CSRs, so that software can context-switch them.

Top module: `vliw_subpc_tracker`

## Requirements
- R1: After reset, `subPc` is 0, `mainPc` is 0, `grpActive` is 0, `illegalBr` is 0, and all four exception sub-PC registers read 0.
- R2: When `grpStart` is taken, then on the next cycle `subPc` is 0, `mainPc` equals `grpBase`, and `grpActive` is 1 if `grpLen` is non-zero. If `grpLen` is zero, `grpActive` is 0.
- R3: While a group is active, `mainPc` does not change on completions, branches or refused branches.
- R4: An `instDone` during an active group adds `instSize` to `subPc` when the sum is below the group length.
- R5: When `subPc + instSize` reaches or passes the group length, `subPc` becomes the group length and `grpActive` is cleared.
- R6: A `brReq` during an active group computes target = `subPc` + `brOff`. `brOff` is a two's-complement value of SPC_W+1 bits. If 0 <= target < length, `subPc` takes the target on the next cycle.
- R7: A branch whose target is negative or at or above the length does not change `subPc` or `grpActive`, and `illegalBr` is 1 for the following cycle.
- R8: `trapTake` stores `subPc` into the exception sub-PC register selected by `trapPriv` and clears `grpActive`. The `trapPriv` encoding is 0 user, 1 supervisor, 2 hypervisor, 3 machine.
- R9: `trapRet` loads `subPc` from the register selected by `retPriv`, using its value before any CSR write in the same cycle. `grpActive` is set only if that value is below the group length.
- R10: `csrRdata` always shows the register selected by `csrSel`. When `csrWe` is high, `csrWdata` is written into that register at the clock edge.
- R11: If a trap save and a CSR write target the same register in the same cycle, the trap save wins. If they target different registers, both take effect.
- R12: Priority is trap, then return, then group start, then branch, then completion. `brReq` and `instDone` are ignored while no group is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpStart | input | 1 | Begin a VLIW group |
| grpBase | input | ADDR_W | Address of the group's first byte |
| grpLen | input | SPC_W | Group length in bytes |
| instDone | input | 1 | An embedded instruction completed |
| instSize | input | SPC_W | Byte size of the completed instruction |
| brReq | input | 1 | Branch request within the group |
| brOff | input | SPC_W+1 | Signed branch offset from the current sub-PC |
| trapTake | input | 1 | Trap entry |
| trapPriv | input | 2 | Privilege level taking the trap |
| trapRet | input | 1 | Return from trap |
| retPriv | input | 2 | Privilege level being returned from |
| csrWe | input | 1 | Write strobe for the exception sub-PC CSRs |
| csrSel | input | 2 | CSR select (privilege level) |
| csrWdata | input | SPC_W | CSR write data |
| csrRdata | output | SPC_W | Selected exception sub-PC value |
| subPc | output | SPC_W | Group-relative program counter |
| mainPc | output | ADDR_W | Architectural PC held at the group base |
| grpActive | output | 1 | Group running; remap and predicate entries apply |
| illegalBr | output | 1 | The previous cycle's branch was refused |

## Verification
A trap save and a CSR write can land on the same exception sub-PC register in the same clock cycle. The bench drives `trapTake` and `csrWe` together, once with `csrSel` equal to `trapPriv` and once with a different select. It reads the registers back through `csrRdata`. In the first case it expects the saved sub-PC, and in the second it expects both values. A second collision drives a return together with a CSR write to the register being restored. The bench checks that the restore uses the old value.

// File: rtl/vliw_subpc_pkg.sv
package vliw_subpc_pkg;
  localparam int NPRIV  = 4;
  localparam int PRIV_W = $clog2(NPRIV);

  typedef struct packed {
    logic start;
    logic branch;
    logic advance;
    logic save;
    logic restore;
  } ctlStrb_t;
endpackage

// File: rtl/vliw_subpc_dp.sv
module vliw_subpc_dp
  import vliw_subpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] grpBase,
  input  logic [SPC_W-1:0]  grpLen,
  input  logic [SPC_W-1:0]  instSize,
  input  logic [SPC_W:0]    brOff,
  input  logic [PRIV_W-1:0] trapPriv,
  input  logic [PRIV_W-1:0] retPriv,
  input  logic              csrWe,
  input  logic [PRIV_W-1:0] csrSel,
  input  logic [SPC_W-1:0]  csrWdata,
  output logic [SPC_W-1:0]  csrRdata,
  output logic [SPC_W-1:0]  subPc,
  output logic [ADDR_W-1:0] mainPc,
  output logic              startNz,
  output logic              brInRange,
  output logic              advEnds,
  output logic              retInRange
);
  logic [SPC_W-1:0] lenQ;
  logic [NPRIV-1:0][SPC_W-1:0] epcQ;
  logic [SPC_W:0] brTgt;
  logic [SPC_W:0] advSum;

  // Target arithmetic is modulo 2^(SPC_W+1); the top bit flags a negative or far target.
  assign brTgt      = {1'b0, subPc} + brOff;
  assign brInRange  = !brTgt[SPC_W] && (brTgt[SPC_W-1:0] < lenQ);
  assign advSum     = {1'b0, subPc} + {1'b0, instSize};
  assign advEnds    = advSum >= {1'b0, lenQ};
  assign retInRange = epcQ[retPriv] < lenQ;
  assign startNz    = |grpLen;
  assign csrRdata   = epcQ[csrSel];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subPc  <= '0;
      mainPc <= '0;
      lenQ   <= '0;
    end else if (strb.restore) begin
      subPc <= epcQ[retPriv];
    end else if (strb.start) begin
      subPc  <= '0;
      mainPc <= grpBase;
      lenQ   <= grpLen;
    end else if (strb.branch) begin
      subPc <= brTgt[SPC_W-1:0];
    end else if (strb.advance) begin
      subPc <= advEnds ? lenQ : advSum[SPC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NPRIV; p++) begin
      if (!rstN) begin
        epcQ[p] <= '0;
      end else if (strb.save && trapPriv == PRIV_W'(p)) begin
        epcQ[p] <= subPc;
      end else if (csrWe && csrSel == PRIV_W'(p)) begin
        epcQ[p] <= csrWdata;
      end
    end
  end
endmodule

// File: rtl/vliw_subpc_ctrl.sv
module vliw_subpc_ctrl
  import vliw_subpc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     grpStart,
  input  logic     instDone,
  input  logic     brReq,
  input  logic     trapTake,
  input  logic     trapRet,
  input  logic     startNz,
  input  logic     brInRange,
  input  logic     advEnds,
  input  logic     retInRange,
  output ctlStrb_t strb,
  output logic     grpActive,
  output logic     illegalBr
);
  logic activeNxt;
  logic illegalNxt;

  always_comb begin
    strb       = '0;
    activeNxt  = grpActive;
    illegalNxt = 1'b0;
    strb.save  = trapTake;
    if (trapTake) begin
      activeNxt = 1'b0;
    end else if (trapRet) begin
      strb.restore = 1'b1;
      activeNxt    = retInRange;
    end else if (grpStart) begin
      strb.start = 1'b1;
      activeNxt  = startNz;
    end else if (grpActive && brReq) begin
      if (brInRange) strb.branch = 1'b1;
      else           illegalNxt  = 1'b1;
    end else if (grpActive && instDone) begin
      strb.advance = 1'b1;
      if (advEnds) activeNxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grpActive <= 1'b0;
      illegalBr <= 1'b0;
    end else begin
      grpActive <= activeNxt;
      illegalBr <= illegalNxt;
    end
  end
endmodule

// File: rtl/vliw_subpc_tracker.sv
module vliw_subpc_tracker
  import vliw_subpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SPC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              grpStart,
  input  logic [ADDR_W-1:0] grpBase,
  input  logic [SPC_W-1:0]  grpLen,
  input  logic              instDone,
  input  logic [SPC_W-1:0]  instSize,
  input  logic              brReq,
  input  logic [SPC_W:0]    brOff,
  input  logic              trapTake,
  input  logic [1:0]        trapPriv,
  input  logic              trapRet,
  input  logic [1:0]        retPriv,
  input  logic              csrWe,
  input  logic [1:0]        csrSel,
  input  logic [SPC_W-1:0]  csrWdata,
  output logic [SPC_W-1:0]  csrRdata,
  output logic [SPC_W-1:0]  subPc,
  output logic [ADDR_W-1:0] mainPc,
  output logic              grpActive,
  output logic              illegalBr
);
  ctlStrb_t strb;
  logic startNz, brInRange, advEnds, retInRange;

  vliw_subpc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .grpStart(grpStart), .instDone(instDone),
    .brReq(brReq), .trapTake(trapTake), .trapRet(trapRet),
    .startNz(startNz), .brInRange(brInRange), .advEnds(advEnds),
    .retInRange(retInRange), .strb(strb), .grpActive(grpActive),
    .illegalBr(illegalBr)
  );

  vliw_subpc_dp #(.ADDR_W(ADDR_W), .SPC_W(SPC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grpBase(grpBase), .grpLen(grpLen),
    .instSize(instSize), .brOff(brOff), .trapPriv(trapPriv), .retPriv(retPriv),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .subPc(subPc), .mainPc(mainPc), .startNz(startNz), .brInRange(brInRange),
    .advEnds(advEnds), .retInRange(retInRange)
  );
endmodule

// File: rtl/vliw_subpc_chk.sv
module vliw_subpc_chk #(
  parameter int ADDR_W = 32,
  parameter int SPC_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              grpStart,
  input logic [ADDR_W-1:0] grpBase,
  input logic              brReq,
  input logic              trapTake,
  input logic              trapRet,
  input logic [SPC_W-1:0]  subPc,
  input logic [ADDR_W-1:0] mainPc,
  input logic              grpActive,
  input logic              illegalBr
);
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (grpStart && !trapTake && !trapRet) |=> subPc == '0); // R2
  AST_START_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (grpStart && !trapTake && !trapRet) |=> mainPc == $past(grpBase)); // R2
  AST_MAINPC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (grpActive && !grpStart) |=> $stable(mainPc)); // R3
  AST_ILLEGAL_FROM_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(illegalBr) |-> $past(brReq)); // R7
  AST_TRAP_SUSPENDS: assert property (@(posedge clk) disable iff (!rstN)
    trapTake |=> !grpActive && !illegalBr); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!grpActive && !grpStart && !trapRet) |=> $stable(subPc)); // R12
endmodule

bind vliw_subpc_tracker vliw_subpc_chk #(.ADDR_W(ADDR_W), .SPC_W(SPC_W)) i_chk (
  .clk(clk), .rstN(rstN), .grpStart(grpStart), .grpBase(grpBase), .brReq(brReq),
  .trapTake(trapTake), .trapRet(trapRet), .subPc(subPc), .mainPc(mainPc),
  .grpActive(grpActive), .illegalBr(illegalBr)
);

// File: tb/test_vliw_subpc_tracker.sv
`timescale 1ns/1ps
module test_vliw_subpc_tracker;
  localparam int ADDR_W = 32;
  localparam int SPC_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic grpStart = 0, instDone = 0, brReq = 0, trapTake = 0, trapRet = 0, csrWe = 0;
  logic [ADDR_W-1:0] grpBase = '0;
  logic [SPC_W-1:0] grpLen = '0, instSize = '0, csrWdata = '0;
  logic [SPC_W:0] brOff = '0;
  logic [1:0] trapPriv = '0, retPriv = '0, csrSel = '0;
  logic [SPC_W-1:0] csrRdata, subPc;
  logic [ADDR_W-1:0] mainPc;
  logic grpActive, illegalBr;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [SPC_W-1:0]  sub;
    logic [ADDR_W-1:0] mpc;
    logic              act;
    logic              ill;
    logic [SPC_W-1:0]  rd;
    string             tag;
  } item_t;
  item_t expQ[$];

  logic [SPC_W-1:0]  mSub = '0, mLen = '0;
  logic [ADDR_W-1:0] mMpc = '0;
  logic              mAct = 0;
  logic [SPC_W-1:0]  mEpc [4];

  always #4 clk = ~clk;

  vliw_subpc_tracker #(.ADDR_W(ADDR_W), .SPC_W(SPC_W)) i_vliw_subpc_tracker (
    .clk(clk), .rstN(rstN), .grpStart(grpStart), .grpBase(grpBase), .grpLen(grpLen),
    .instDone(instDone), .instSize(instSize), .brReq(brReq), .brOff(brOff),
    .trapTake(trapTake), .trapPriv(trapPriv), .trapRet(trapRet), .retPriv(retPriv),
    .csrWe(csrWe), .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .subPc(subPc), .mainPc(mainPc), .grpActive(grpActive), .illegalBr(illegalBr)
  );

  task automatic idle();
    grpStart = 0; instDone = 0; brReq = 0; trapTake = 0; trapRet = 0; csrWe = 0;
  endtask

  // Driver: computes the expected post-edge state from the requirements and queues it.
  task automatic go(string tag);
    item_t e;
    logic [SPC_W-1:0] oldEpc [4];
    logic [SPC_W:0] tgt, sum;
    logic mIll;
    for (int i = 0; i < 4; i++) oldEpc[i] = mEpc[i];
    mIll = 0;
    if (trapTake) begin
      mEpc[trapPriv] = mSub; mAct = 0;
    end else if (trapRet) begin
      mSub = oldEpc[retPriv]; mAct = oldEpc[retPriv] < mLen;
    end else if (grpStart) begin
      mSub = '0; mMpc = grpBase; mLen = grpLen; mAct = grpLen != 0;
    end else if (mAct && brReq) begin
      tgt = {1'b0, mSub} + brOff;
      if (!tgt[SPC_W] && tgt[SPC_W-1:0] < mLen) mSub = tgt[SPC_W-1:0];
      else mIll = 1;
    end else if (mAct && instDone) begin
      sum = {1'b0, mSub} + {1'b0, instSize};
      if (sum >= {1'b0, mLen}) begin mSub = mLen; mAct = 0; end
      else mSub = sum[SPC_W-1:0];
    end
    if (csrWe && !(trapTake && trapPriv == csrSel)) mEpc[csrSel] = csrWdata;
    e.sub = mSub; e.mpc = mMpc; e.act = mAct; e.ill = mIll; e.rd = mEpc[csrSel]; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    idle();
  endtask

  // Monitor: samples just after each active edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      item_t e;
      e = expQ.pop_front();
      checks++;
      if (subPc !== e.sub || mainPc !== e.mpc || grpActive !== e.act ||
          illegalBr !== e.ill || csrRdata !== e.rd) begin
        failures++;
        $display("FAIL %s: sub=%0d mpc=%h act=%0b ill=%0b rd=%0d exp sub=%0d mpc=%h act=%0b ill=%0b rd=%0d",
                 e.tag, subPc, mainPc, grpActive, illegalBr, csrRdata,
                 e.sub, e.mpc, e.act, e.ill, e.rd);
      end
    end
  end

  task automatic start(logic [ADDR_W-1:0] b, logic [SPC_W-1:0] l, string tag);
    grpStart = 1; grpBase = b; grpLen = l; go(tag);
  endtask
  task automatic done(logic [SPC_W-1:0] s, string tag);
    instDone = 1; instSize = s; go(tag);
  endtask
  task automatic branch(int off, string tag);
    brReq = 1; brOff = (SPC_W+1)'(off); go(tag);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mEpc[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      csrSel = 2'(i); #1;
      checks++;
      if (subPc !== 0 || mainPc !== 0 || grpActive !== 0 || illegalBr !== 0 || csrRdata !== 0) begin
        failures++;
        $display("FAIL R1: sub=%0d mpc=%h act=%0b ill=%0b rd=%0d exp all 0",
                 subPc, mainPc, grpActive, illegalBr, csrRdata);
      end
    end
    csrSel = 0;
    rstN = 1;
    @(negedge clk);

    start(32'h8000_0100, 20, "R2 start");
    done(4, "R4 advance");
    done(4, "R4 R3 advance holds mainPc");
    branch(6, "R6 forward branch");
    branch(-14, "R6 backward branch to 0");
    branch(20, "R7 target equals length");
    branch(-1, "R7 negative target");
    brReq = 1; brOff = 9'(30); instDone = 1; instSize = 2; go("R12 R7 branch beats completion");
    done(6, "R4 advance to 6");
    trapTake = 1; trapPriv = 3; csrSel = 3; go("R8 trap machine");
    done(4, "R12 completion ignored when inactive");
    branch(2, "R12 branch ignored when inactive");
    csrWe = 1; csrSel = 1; csrWdata = 9; go("R10 csr write supervisor");
    trapRet = 1; retPriv = 3; csrSel = 3; go("R9 return machine");
    done(3, "R4 advance after return");
    trapTake = 1; trapPriv = 1; csrWe = 1; csrSel = 1; csrWdata = 8'h33; go("R11 trap beats csr same slot");
    trapTake = 1; trapPriv = 2; csrWe = 1; csrSel = 0; csrWdata = 5; go("R11 trap and csr different slots");
    csrSel = 2; go("R11 readback hypervisor");
    trapRet = 1; retPriv = 0; csrSel = 0; go("R9 return user in range");
    csrWe = 1; csrSel = 2; csrWdata = 200; go("R10 csr write hypervisor");
    trapRet = 1; retPriv = 2; go("R9 return out of range");
    trapRet = 1; retPriv = 1; csrWe = 1; csrSel = 1; csrWdata = 7; go("R9 restore uses old value");
    start(32'h0000_4000, 0, "R2 zero length");
    done(1, "R12 completion ignored zero length");
    start(32'h0000_5000, 10, "R2 restart");
    done(12, "R5 overshoot ends group");
    start(32'h0000_6000, 10, "R2 restart");
    done(4, "R4 advance");
    done(6, "R5 exact end");
    start(32'h0000_7000, 50, "R2 restart");
    branch(49, "R6 branch to last byte");
    branch(200, "R7 far target");
    grpStart = 1; grpBase = 32'h9; grpLen = 8; trapTake = 1; trapPriv = 0; go("R12 trap beats start");
    grpStart = 1; grpBase = 32'hA; grpLen = 8; trapRet = 1; retPriv = 0; go("R12 return beats start");

    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule